// File: doc/BRIEF.md
# Two-Way Mailbox with Doorbell Registers

This block is a shared register bank that lets a host processor and a service controller pass messages to each other. Each agent has its own addressed register port with a request valid, a write flag, a word address and 64-bit write data. Eight 64-bit mailbox words hold the payload. The lower half carries requests from the host and the upper half carries responses from the controller. Two 64-bit doorbell registers signal events, one for each direction. Each doorbell has three addresses. One replaces the value. One ANDs the written data in, to clear bits atomically. One ORs the written data in, to set bits atomically.

Bits are numbered from the most significant end, so doorbell bit 0 is data bit 63. Host-to-controller doorbell bit 0 means a request is pending, and it drives the controller interrupt. In the controller-to-host doorbell, bit 0 means a response is ready, bit 1 means the request was taken, and bit 2 asks for a host thread wake-up. Any of these three bits drives the host interrupt. Both interrupts are levels taken straight from the stored bits.

The request ports carry no ready signal: the block accepts every request on the cycle it is presented, so there is no back-pressure. A read is answered exactly one cycle later by the response valid and the read data. The response side cannot stall either, so the agent must take the answer in that cycle.

Top module: `mbx_dual_mailbox`

## Requirements
- R1: After reset every mailbox word and both doorbells read as zero, both interrupts are low, and no response valid or error flag is asserted.
- R2: Mailbox word i sits at word address 0x000D0050+i for i from 0 to 7. Either agent can write it and either agent can read it. A read request gives response valid and the data exactly one cycle later. A write request gives no response valid.
- R3: When both agents write the same mailbox word in one cycle, the host's data is stored for words 0 to 3 and the controller's data is stored for words 4 to 7.
- R4: A plain doorbell write replaces the whole register. The host-to-controller plain address is 0x000D0060 and the controller-to-host plain address is 0x000D0063. A read from any of a doorbell's three addresses returns that doorbell's current value.
- R5: Writing the AND alias (0x000D0061 / 0x000D0064) stores register AND data. Writing the OR alias (0x000D0062 / 0x000D0065) stores register OR data.
- R6: When writes to one doorbell meet in one cycle, the plain value is taken first, the AND masks are applied next and the OR masks last. A bit that is set in the same cycle as it is cleared therefore ends up set. If both agents write the plain address, the sending agent wins: the host for the host-to-controller doorbell, the controller for the other.
- R7: The controller interrupt is high exactly while host-to-controller doorbell bit 0 (data bit 63) is set.
- R8: The host interrupt is high exactly while any of controller-to-host doorbell bits 0 to 2 (data bits 63:61) is set. Other doorbell bits are stored and read back, but they raise no interrupt.
- R9: A request to an address outside the mapped ones raises the error flag for one cycle, one cycle after the request. A read of such an address returns zero data with response valid. A write to such an address changes no register.
- R10: A write takes effect at the next clock edge. A read in the same cycle as a write to the same register returns the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_req_valid | input | 1 | Host request present |
| host_req_write | input | 1 | Host request is a write |
| host_req_addr | input | 32 | Host word address |
| host_req_wdata | input | 64 | Host write data |
| host_rsp_valid | output | 1 | Host read answer valid |
| host_rsp_rdata | output | 64 | Host read data |
| host_rsp_err | output | 1 | Host request hit an unmapped address |
| ctrl_req_valid | input | 1 | Controller request present |
| ctrl_req_write | input | 1 | Controller request is a write |
| ctrl_req_addr | input | 32 | Controller word address |
| ctrl_req_wdata | input | 64 | Controller write data |
| ctrl_rsp_valid | output | 1 | Controller read answer valid |
| ctrl_rsp_rdata | output | 64 | Controller read data |
| ctrl_rsp_err | output | 1 | Controller request hit an unmapped address |
| irq_to_ctrl | output | 1 | Level interrupt to the controller |
| irq_to_host | output | 1 | Level interrupt to the host |

## Verification
The bench builds the block with its default parameters: eight 64-bit words, the default base addresses, and interrupt masks on data bit 63 and on data bits 63:61. With eight words, the host-owned lower half and the controller-owned upper half can both be reached by same-cycle collisions. With a full 64-bit word, the MSB-first handshake bits can be told apart from stored bits that raise no interrupt. The addresses just past the mailbox words and just past the last doorbell alias exercise the decode boundaries.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int AGENTS  = 2;
  localparam int AG_HOST = 0;
  localparam int AG_CTRL = 1;
  localparam int DB_ALIASES = 3;

  typedef enum logic [1:0] {
    DB_RW  = 2'd0,
    DB_AND = 2'd1,
    DB_OR  = 2'd2
  } db_op_e;

  typedef struct packed {
    logic   hit_mbx;
    logic   hit_db;
    logic   db_sel;
    db_op_e op;
    logic   unmapped;
  } dec_t;
endpackage

// File: rtl/mbx_decode.sv
module mbx_decode #(
  parameter int ADDR_W = 32,
  parameter int MBX_COUNT = 8,
  parameter logic [ADDR_W-1:0] MBX_BASE = 'h000D0050,
  parameter logic [ADDR_W-1:0] DB_H2C_BASE = 'h000D0060,
  parameter logic [ADDR_W-1:0] DB_C2H_BASE = 'h000D0063,
  localparam int IDX_W = (MBX_COUNT > 1) ? $clog2(MBX_COUNT) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output mbx_pkg::dec_t     dec,
  output logic [IDX_W-1:0]  mbx_idx
);
  logic [ADDR_W-1:0] off_m, off_h, off_c;
  logic in_h, in_c;

  always_comb begin
    off_m = addr - MBX_BASE;
    off_h = addr - DB_H2C_BASE;
    off_c = addr - DB_C2H_BASE;
    in_h  = (addr >= DB_H2C_BASE) && (off_h < ADDR_W'(mbx_pkg::DB_ALIASES));
    in_c  = (addr >= DB_C2H_BASE) && (off_c < ADDR_W'(mbx_pkg::DB_ALIASES));
    dec.hit_mbx  = (addr >= MBX_BASE) && (off_m < ADDR_W'(MBX_COUNT));
    dec.hit_db   = in_h || in_c;
    dec.db_sel   = in_c;
    dec.op       = in_c ? mbx_pkg::db_op_e'(off_c[1:0])
                        : mbx_pkg::db_op_e'(off_h[1:0]);
    dec.unmapped = !(dec.hit_mbx || dec.hit_db);
    mbx_idx      = off_m[IDX_W-1:0];
  end
endmodule

// File: rtl/mbx_word.sv
module mbx_word #(
  parameter int DATA_W = 64,
  parameter int OWNER = 0
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic [mbx_pkg::AGENTS-1:0]               wr_en,
  input  logic [mbx_pkg::AGENTS-1:0][DATA_W-1:0]   wdata,
  output logic [DATA_W-1:0]                        q
);
  logic [DATA_W-1:0] nxt;

  always_comb begin
    nxt = q;
    for (int a = 0; a < mbx_pkg::AGENTS; a++)
      if (wr_en[a] && a != OWNER) nxt = wdata[a];
    if (wr_en[OWNER]) nxt = wdata[OWNER];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end

  // R3: the owning agent's data is the one stored
  p_owner_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en[OWNER] |=> q == $past(wdata[OWNER]));
  p_idle_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(|wr_en) |=> $stable(q));
endmodule

// File: rtl/mbx_doorbell.sv
module mbx_doorbell #(
  parameter int DATA_W = 64,
  parameter int SENDER = 0,
  parameter logic [DATA_W-1:0] IRQ_MASK = {1'b1, {(DATA_W-1){1'b0}}}
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic [mbx_pkg::AGENTS-1:0]             wr_en,
  input  mbx_pkg::db_op_e                        op_i [mbx_pkg::AGENTS],
  input  logic [mbx_pkg::AGENTS-1:0][DATA_W-1:0] wdata,
  output logic [DATA_W-1:0]                      q,
  output logic                                   irq
);
  logic [DATA_W-1:0] base, and_m, or_m, nxt;

  always_comb begin
    base  = q;
    and_m = '1;
    or_m  = '0;
    for (int a = 0; a < mbx_pkg::AGENTS; a++) begin
      if (wr_en[a]) begin
        unique case (op_i[a])
          mbx_pkg::DB_RW:  if (a != SENDER) base = wdata[a];
          mbx_pkg::DB_AND: and_m = and_m & wdata[a];
          mbx_pkg::DB_OR:  or_m  = or_m | wdata[a];
          default: ;
        endcase
      end
    end
    if (wr_en[SENDER] && op_i[SENDER] == mbx_pkg::DB_RW) base = wdata[SENDER];
    nxt = (base & and_m) | or_m;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end

  assign irq = |(q & IRQ_MASK);

  // R6: OR-set bits survive any same-cycle clear
  p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|or_m) |=> ((q & $past(or_m)) == $past(or_m)));
  // R5: no write, no change
  p_hold_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(|wr_en) |=> $stable(q));
  // R7 / R8: an interrupt only rises after a write to this doorbell
  p_irq_after_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(|wr_en));
endmodule

// File: rtl/mbx_dual_mailbox.sv
module mbx_dual_mailbox #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int MBX_COUNT = 8,
  parameter logic [ADDR_W-1:0] MBX_BASE = 'h000D0050,
  parameter logic [ADDR_W-1:0] DB_H2C_BASE = 'h000D0060,
  parameter logic [ADDR_W-1:0] DB_C2H_BASE = 'h000D0063,
  parameter logic [DATA_W-1:0] H2C_IRQ_MASK = {1'b1, {(DATA_W-1){1'b0}}},
  parameter logic [DATA_W-1:0] C2H_IRQ_MASK = {3'b111, {(DATA_W-3){1'b0}}}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_req_valid,
  input  logic              host_req_write,
  input  logic [ADDR_W-1:0] host_req_addr,
  input  logic [DATA_W-1:0] host_req_wdata,
  output logic              host_rsp_valid,
  output logic [DATA_W-1:0] host_rsp_rdata,
  output logic              host_rsp_err,
  input  logic              ctrl_req_valid,
  input  logic              ctrl_req_write,
  input  logic [ADDR_W-1:0] ctrl_req_addr,
  input  logic [DATA_W-1:0] ctrl_req_wdata,
  output logic              ctrl_rsp_valid,
  output logic [DATA_W-1:0] ctrl_rsp_rdata,
  output logic              ctrl_rsp_err,
  output logic              irq_to_ctrl,
  output logic              irq_to_host
);
  import mbx_pkg::*;
  localparam int IDX_W = (MBX_COUNT > 1) ? $clog2(MBX_COUNT) : 1;
  localparam int HALF  = MBX_COUNT / 2;

  logic [AGENTS-1:0]             req_v, req_w;
  logic [AGENTS-1:0][ADDR_W-1:0] req_a;
  logic [AGENTS-1:0][DATA_W-1:0] req_d;
  dec_t                          dec   [AGENTS];
  logic [IDX_W-1:0]              idx   [AGENTS];
  db_op_e                        op_a  [AGENTS];
  logic [DATA_W-1:0]             mbx_q [MBX_COUNT];
  logic [DATA_W-1:0]             db_q  [2];
  logic [1:0]                    db_irq;
  logic [AGENTS-1:0]             rsp_v, rsp_e;
  logic [AGENTS-1:0][DATA_W-1:0] rsp_d;

  assign req_v = {ctrl_req_valid, host_req_valid};
  assign req_w = {ctrl_req_write, host_req_write};
  assign req_a = {ctrl_req_addr,  host_req_addr};
  assign req_d = {ctrl_req_wdata, host_req_wdata};

  for (genvar a = 0; a < AGENTS; a++) begin : g_agent
    logic [DATA_W-1:0] rd;

    mbx_decode #(
      .ADDR_W(ADDR_W), .MBX_COUNT(MBX_COUNT), .MBX_BASE(MBX_BASE),
      .DB_H2C_BASE(DB_H2C_BASE), .DB_C2H_BASE(DB_C2H_BASE)
    ) u_dec (
      .addr(req_a[a]), .dec(dec[a]), .mbx_idx(idx[a])
    );

    assign op_a[a] = dec[a].op;

    always_comb begin
      rd = '0;
      if (dec[a].hit_mbx)     rd = mbx_q[idx[a]];
      else if (dec[a].hit_db) rd = db_q[dec[a].db_sel];
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rsp_v[a] <= 1'b0;
        rsp_d[a] <= '0;
        rsp_e[a] <= 1'b0;
      end else begin
        rsp_v[a] <= req_v[a] && !req_w[a];
        rsp_d[a] <= (req_v[a] && !req_w[a]) ? rd : '0;
        rsp_e[a] <= req_v[a] && dec[a].unmapped;
      end
    end
  end

  for (genvar w = 0; w < MBX_COUNT; w++) begin : g_word
    logic [AGENTS-1:0] wen;
    for (genvar a = 0; a < AGENTS; a++) begin : g_en
      assign wen[a] = req_v[a] && req_w[a] && dec[a].hit_mbx &&
                      (idx[a] == IDX_W'(w));
    end
    mbx_word #(
      .DATA_W(DATA_W), .OWNER((w < HALF) ? AG_HOST : AG_CTRL)
    ) u_word (
      .clk(clk), .rst_n(rst_n), .wr_en(wen), .wdata(req_d), .q(mbx_q[w])
    );
  end

  for (genvar d = 0; d < 2; d++) begin : g_db
    logic [AGENTS-1:0] wen;
    for (genvar a = 0; a < AGENTS; a++) begin : g_en
      assign wen[a] = req_v[a] && req_w[a] && dec[a].hit_db &&
                      (dec[a].db_sel == d[0]);
    end
    mbx_doorbell #(
      .DATA_W(DATA_W), .SENDER((d == 0) ? AG_HOST : AG_CTRL),
      .IRQ_MASK((d == 0) ? H2C_IRQ_MASK : C2H_IRQ_MASK)
    ) u_db (
      .clk(clk), .rst_n(rst_n), .wr_en(wen), .op_i(op_a), .wdata(req_d),
      .q(db_q[d]), .irq(db_irq[d])
    );
  end

  assign irq_to_ctrl    = db_irq[0];
  assign irq_to_host    = db_irq[1];
  assign host_rsp_valid = rsp_v[AG_HOST];
  assign host_rsp_rdata = rsp_d[AG_HOST];
  assign host_rsp_err   = rsp_e[AG_HOST];
  assign ctrl_rsp_valid = rsp_v[AG_CTRL];
  assign ctrl_rsp_rdata = rsp_d[AG_CTRL];
  assign ctrl_rsp_err   = rsp_e[AG_CTRL];

  p_read_answers_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req_valid && !host_req_write) |=> host_rsp_valid);
  p_write_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_req_valid && ctrl_req_write) |=> !ctrl_rsp_valid);
  p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rsp_valid && host_rsp_err) |-> host_rsp_rdata == '0);
  p_ctrl_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_rsp_valid && ctrl_rsp_err) |-> ctrl_rsp_rdata == '0);
endmodule

// File: tb/mbx_dual_mailbox_bench.sv
`timescale 1ns/1ps
module mbx_dual_mailbox_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        rv [2];
  logic        rw [2];
  logic [31:0] ra [2];
  logic [63:0] rd [2];
  logic [1:0]        rsp_v, rsp_e;
  logic [63:0]       rsp_d [2];
  logic              irq_c, irq_h;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  mbx_dual_mailbox u_mbx_dual_mailbox (
    .clk(clk), .rst_n(rst_n),
    .host_req_valid(rv[0]), .host_req_write(rw[0]), .host_req_addr(ra[0]),
    .host_req_wdata(rd[0]), .host_rsp_valid(rsp_v[0]), .host_rsp_rdata(rsp_d[0]),
    .host_rsp_err(rsp_e[0]),
    .ctrl_req_valid(rv[1]), .ctrl_req_write(rw[1]), .ctrl_req_addr(ra[1]),
    .ctrl_req_wdata(rd[1]), .ctrl_rsp_valid(rsp_v[1]), .ctrl_rsp_rdata(rsp_d[1]),
    .ctrl_rsp_err(rsp_e[1]),
    .irq_to_ctrl(irq_c), .irq_to_host(irq_h)
  );

  // reference state
  logic [63:0] m_mbx [8];
  logic [63:0] m_db  [2];

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // kind: 0 mailbox, 1 doorbell, 2 unmapped
  function automatic void classify(logic [31:0] a, output int kind,
                                   output int idx, output int op);
    kind = 2; idx = 0; op = 0;
    if (a >= 32'h000D0050 && a < 32'h000D0058) begin
      kind = 1 - 1; idx = int'(a - 32'h000D0050);
    end else if (a >= 32'h000D0060 && a < 32'h000D0066) begin
      kind = 1;
      idx  = (a >= 32'h000D0063) ? 1 : 0;
      op   = int'(a - (idx == 1 ? 32'h000D0063 : 32'h000D0060));
    end
  endfunction

  task automatic setreq(int a, bit v, bit w, logic [31:0] addr, logic [63:0] d);
    rv[a] = v; rw[a] = w; ra[a] = addr; rd[a] = d;
  endtask

  task automatic idle();
    for (int a = 0; a < 2; a++) setreq(a, 0, 0, 32'h0, 64'h0);
  endtask

  task automatic step(string tag);
    logic        ev [2];
    logic [63:0] ed [2];
    logic        ee [2];
    logic [63:0] nmbx [8];
    logic [63:0] base, andm, orm;
    int kind, idx, op;
    for (int a = 0; a < 2; a++) begin
      classify(ra[a], kind, idx, op);
      ev[a] = rv[a] && !rw[a];
      ee[a] = rv[a] && (kind == 2);
      ed[a] = 64'h0;
      if (ev[a] && kind == 0) ed[a] = m_mbx[idx];
      if (ev[a] && kind == 1) ed[a] = m_db[idx];
    end
    for (int i = 0; i < 8; i++) nmbx[i] = m_mbx[i];
    for (int p = 0; p < 2; p++)
      for (int a = 0; a < 2; a++) begin
        classify(ra[a], kind, idx, op);
        if (rv[a] && rw[a] && kind == 0)
          if ((p == 1) == (a == ((idx < 4) ? 0 : 1))) nmbx[idx] = rd[a];
      end
    for (int k = 0; k < 2; k++) begin
      base = m_db[k]; andm = '1; orm = '0;
      for (int p = 0; p < 2; p++)
        for (int a = 0; a < 2; a++) begin
          classify(ra[a], kind, idx, op);
          if (rv[a] && rw[a] && kind == 1 && idx == k) begin
            if (op == 0 && ((p == 1) == (a == k))) base = rd[a];
            if (p == 0 && op == 1) andm &= rd[a];
            if (p == 0 && op == 2) orm |= rd[a];
          end
        end
      m_db[k] = (base & andm) | orm;
    end
    for (int i = 0; i < 8; i++) m_mbx[i] = nmbx[i];
    @(posedge clk);
    @(negedge clk);
    for (int a = 0; a < 2; a++) begin
      chk(tag, $sformatf("agent%0d rsp_valid", a), 64'(rsp_v[a]), 64'(ev[a]));
      chk(tag, $sformatf("agent%0d rdata", a), rsp_d[a], ed[a]);
      chk(tag, $sformatf("agent%0d err", a), 64'(rsp_e[a]), 64'(ee[a]));
    end
    chk(tag, "irq_to_ctrl", 64'(irq_c), 64'(m_db[0][63]));
    chk(tag, "irq_to_host", 64'(irq_h), 64'(|m_db[1][63:61]));
    idle();
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle();
    for (int i = 0; i < 8; i++) m_mbx[i] = '0;
    m_db[0] = '0; m_db[1] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step("R1");
    for (int i = 0; i < 8; i++) begin setreq(i % 2, 1, 0, 32'h000D0050 + i, 0); step("R1"); end
    setreq(0, 1, 0, 32'h000D0060, 0); setreq(1, 1, 0, 32'h000D0065, 0); step("R1");

    // R2: fill words from alternating agents, read back crosswise
    for (int i = 0; i < 8; i++) begin
      setreq(i % 2, 1, 1, 32'h000D0050 + i, 64'hA5A5_0000_0000_0000 | 64'(i * 17)); step("R2");
    end
    for (int i = 0; i < 8; i++) begin
      setreq((i + 1) % 2, 1, 0, 32'h000D0050 + i, 0); setreq(i % 2, 1, 0, 32'h000D0057 - i, 0);
      step("R2");
    end

    // R10: read and write of one word in the same cycle
    setreq(0, 1, 1, 32'h000D0052, 64'h1111_2222_3333_4444);
    setreq(1, 1, 0, 32'h000D0052, 0); step("R10");
    setreq(1, 1, 0, 32'h000D0052, 0); step("R10");

    // R3: collisions in both halves
    setreq(0, 1, 1, 32'h000D0051, 64'hAAAA); setreq(1, 1, 1, 32'h000D0051, 64'hBBBB); step("R3");
    setreq(0, 1, 1, 32'h000D0056, 64'hCCCC); setreq(1, 1, 1, 32'h000D0056, 64'hDDDD); step("R3");
    setreq(0, 1, 0, 32'h000D0051, 0); setreq(1, 1, 0, 32'h000D0056, 0); step("R3");

    // R7 / R4 / R5: pending request doorbell
    setreq(0, 1, 1, 32'h000D0060, 64'h8000_0000_0000_00F0); step("R7");
    setreq(1, 1, 0, 32'h000D0061, 0); setreq(0, 1, 0, 32'h000D0062, 0); step("R4");
    setreq(1, 1, 1, 32'h000D0061, 64'h7FFF_FFFF_FFFF_FFFF); step("R5");
    setreq(1, 1, 0, 32'h000D0060, 0); step("R7");
    setreq(0, 1, 1, 32'h000D0060, 64'h4000_0000_0000_0000); step("R7");
    setreq(0, 1, 1, 32'h000D0062, 64'h8000_0000_0000_0000); step("R5");
    setreq(1, 1, 1, 32'h000D0061, 64'h7FFF_FFFF_FFFF_FFFF); step("R5");

    // R8: host interrupt bits and stored undefined bits
    setreq(1, 1, 1, 32'h000D0065, 64'h4000_0000_0000_0000); step("R8");
    setreq(1, 1, 1, 32'h000D0064, 64'h0); step("R8");
    setreq(1, 1, 1, 32'h000D0065, 64'h1000_0000_0000_0001); step("R8");
    setreq(0, 1, 0, 32'h000D0063, 0); step("R8");
    setreq(1, 1, 1, 32'h000D0063, 64'h2000_0000_0000_0000); step("R8");
    setreq(1, 1, 1, 32'h000D0063, 64'h8000_0000_0000_0000); step("R8");
    setreq(0, 1, 1, 32'h000D0064, 64'h7FFF_FFFF_FFFF_FFFF); step("R8");

    // R6: same-cycle collisions on doorbells
    setreq(0, 1, 1, 32'h000D0064, 64'h0); setreq(1, 1, 1, 32'h000D0065, 64'h8000_0000_0000_0000);
    step("R6");
    setreq(0, 1, 1, 32'h000D0063, 64'h0000_0000_0000_00FF);
    setreq(1, 1, 1, 32'h000D0063, 64'h4000_0000_0000_0000); step("R6");
    setreq(0, 1, 1, 32'h000D0060, 64'h8000_0000_0000_0001);
    setreq(1, 1, 1, 32'h000D0060, 64'h0000_0000_0000_0002); step("R6");
    setreq(0, 1, 1, 32'h000D0062, 64'h0000_0000_0000_0100);
    setreq(1, 1, 1, 32'h000D0061, 64'h7FFF_FFFF_FFFF_FEFF); step("R6");
    setreq(0, 1, 0, 32'h000D0060, 0); setreq(1, 1, 0, 32'h000D0063, 0); step("R6");

    // R9: unmapped neighbours
    setreq(0, 1, 0, 32'h000D0058, 0); setreq(1, 1, 0, 32'h000D0066, 0); step("R9");
    setreq(0, 1, 1, 32'h000D004F, 64'hFFFF); setreq(1, 1, 1, 32'h000D005F, 64'hFFFF); step("R9");
    step("R9");
    setreq(1, 1, 1, 32'h0000_0000, 64'hFFFF_FFFF_FFFF_FFFF); step("R9");
    for (int i = 0; i < 8; i++) begin setreq(0, 1, 0, 32'h000D0050 + i, 0); step("R9"); end
    setreq(0, 1, 0, 32'h000D0060, 0); setreq(1, 1, 0, 32'h000D0063, 0); step("R9");

    // R1: reset in the middle clears everything
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 8; i++) m_mbx[i] = '0;
    m_db[0] = '0; m_db[1] = '0;
    step("R1");
    setreq(0, 1, 0, 32'h000D0056, 0); setreq(1, 1, 0, 32'h000D0060, 0); step("R1");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule